// File: doc/BRIEF.md
# Write-Once Retriggerable Watchdog Timer

This block is a watchdog built around a 12-bit down-counter and one control register. The first write to that register sets up the timer: a reload value, a prescaler choice, an enable, and a two-bit field that chooses what happens at timeout. That same write locks the configuration until the next reset. Every write after that reloads the counter from the stored reload value and ignores the data written. Software keeps the system alive by writing to the register often enough to stop the count from reaching zero.

The counter runs from a watchdog tick at half the bus clock rate. This tick comes from an internal divide-by-two enable. With the prescaler on, the counter also waits a further 16384 watchdog ticks between steps. At timeout the block does one of three things, chosen by the locked action field: it holds an interrupt line, it pulses a reset request, or it does nothing. In every case the counter stops at zero. A read returns the locked configuration, a lock flag and the live count.

Top module: `wdt_writeonce`

## Requirements
- R1: After a synchronous active-low reset, rd_data, irq and rst_req are all zero.
- R2: The first write latches wr_data[15:0] as the configuration and sets the lock flag. In the configuration, [11:0] is the reload, [12] the prescaler select, [13] the enable and [15:14] the action. A read returns {3'b0, count[11:0], lock, config[15:0]}, so the count sits in bits 28:17 and the lock flag in bit 16.
- R3: Once the lock flag is set, no further write changes config or lock. Only reset clears them.
- R4: Every write, the first included, loads the count with the reload value. Counting runs only when the locked enable bit is 1. With enable 0 the count holds at the reload value.
- R5: With the prescaler off, the count drops by one every 2 bus cycles. For a reload N of 1 or more, timeout lands on the bus clock edge 2N cycles after the edge that captured the write.
- R6: With the prescaler on, each step takes 16384 watchdog ticks, which is 32768 bus cycles.
- R7: A reload of 0 times out on the first watchdog tick, 2 cycles after the write.
- R8: Action 2 sets irq at timeout. irq stays high until the next write or reset.
- R9: Actions 1 and 3 give a one-cycle rst_req pulse at timeout. Action 0 drives neither output. irq and rst_req are never high together.
- R10: After timeout the count stays at 0. A later write clears irq and restarts counting from the reload value.
- R11: A write before timeout restarts the full period from the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data (configuration on first write, ignored afterwards) |
| rd_data | output | 32 | Register read value |
| irq | output | 1 | Timeout interrupt, level |
| rst_req | output | 1 | Timeout reset request, one-cycle pulse |

## Verification
The hardest case to reach is the prescaled timeout. It only arrives after 32768 bus cycles of idle counting, and the exact cycle depends on the prescaler and divider phases, which are cleared on every write. The bench sets up a reload of 1 with the prescaler on. It then confirms that nothing fires on cycle 32767 and that irq is up on cycle 32768. The lock is reached by writing the configuration first and then writing a conflicting value, whose only visible effect must be a counter reload seen in the read port.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int RELOAD_W = 12;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_RESET = 2'd1,
        ACT_IRQ   = 2'd2,
        ACT_RSVD  = 2'd3
    } wdt_action_e;

    // Bit layout is decoded by software: [15:14] action, [13] enable,
    // [12] prescale select, [11:0] reload.
    typedef struct packed {
        wdt_action_e         action;
        logic                enable;
        logic                prescale;
        logic [RELOAD_W-1:0] reload;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_tickgen.sv
module wdt_tickgen #(
    parameter int PRE_DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic pre_sel,
    output logic tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    typedef struct packed {
        logic             half;
        logic [PRE_W-1:0] pre;
    } tg_state_t;

    tg_state_t s_d, s_q;
    logic      wd_tick;
    logic      pre_wrap;

    always_comb begin
        wd_tick  = run & s_q.half;
        pre_wrap = (s_q.pre == PRE_LAST);
        tick     = wd_tick & (~pre_sel | pre_wrap);
        s_d      = s_q;
        if (restart || !run) begin
            s_d = '0;
        end else begin
            s_d.half = ~s_q.half;
            if (wd_tick && pre_sel)
                s_d.pre = pre_wrap ? '0 : s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         running,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
    } dc_state_t;

    dc_state_t s_d, s_q;
    logic      last_step;

    always_comb begin
        last_step = (s_q.cnt <= W'(1));
        expire    = s_q.run & tick & ~restart & last_step;
        s_d       = s_q;
        if (restart) begin
            s_d.cnt = load_val;
            s_d.run = load_en;
        end else if (s_q.run && tick) begin
            if (last_step) begin
                s_d.cnt = '0;
                s_d.run = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign running = s_q.run;

    AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !restart) |=> s_q.cnt <= $past(s_q.cnt)); // R5
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !restart) |=> $stable(s_q.cnt)); // R10
endmodule

// File: rtl/wdt_writeonce.sv
module wdt_writeonce
    import wdt_pkg::*;
#(
    parameter int PRE_DIV = 16384
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        rst_req
);
    typedef struct packed {
        wdt_cfg_t cfg;
        logic     lock;
        logic     irq;
        logic     rreq;
    } top_state_t;

    top_state_t          s_d, s_q;
    wdt_cfg_t            wr_cfg;
    logic [RELOAD_W-1:0] load_val;
    logic                load_en;
    logic                tick;
    logic                running;
    logic                expire;
    logic [RELOAD_W-1:0] count;

    assign wr_cfg   = wdt_cfg_t'(wr_data);
    assign load_val = s_q.lock ? s_q.cfg.reload : wr_cfg.reload;
    assign load_en  = s_q.lock ? s_q.cfg.enable : wr_cfg.enable;

    wdt_tickgen #(.PRE_DIV(PRE_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en),
        .run     (running),
        .pre_sel (s_q.cfg.prescale),
        .tick    (tick)
    );

    wdt_downcount #(.W(RELOAD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_en),
        .load_en  (load_en),
        .load_val (load_val),
        .tick     (tick),
        .count    (count),
        .running  (running),
        .expire   (expire)
    );

    always_comb begin
        s_d      = s_q;
        s_d.rreq = 1'b0;
        if (wr_en) begin
            if (!s_q.lock) begin
                s_d.cfg  = wr_cfg;
                s_d.lock = 1'b1;
            end
            s_d.irq = 1'b0;
        end else if (expire) begin
            case (s_q.cfg.action)
                ACT_IRQ:             s_d.irq  = 1'b1;
                ACT_RESET, ACT_RSVD: s_d.rreq = 1'b1;
                default:             ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = {3'b000, count, s_q.lock, s_q.cfg};
    assign irq     = s_q.irq;
    assign rst_req = s_q.rreq;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lock |=> (s_q.lock && $stable(s_q.cfg))); // R3
    AST_IRQ_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !s_q.irq); // R8
    AST_RREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rreq |=> !s_q.rreq); // R9
    AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rreq |-> !s_q.irq); // R9
endmodule

// File: tb/sim_wdt_writeonce.sv
module sim_wdt_writeonce;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wdt_writeonce u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_exp(logic [15:0] cfg, logic [11:0] cnt);
        return {3'b000, cnt, 1'b1, cfg};
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // Returns on the negedge after the capturing edge.
    task automatic do_write(logic [15:0] d);
        @(negedge clk) wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk) wr_en = 1'b0;
    endtask

    // Cycles from the write edge until irq or rst_req shows (limit if never).
    task automatic wait_fire(int limit, output int n);
        n = 0;
        while (!(irq || rst_req) && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);
    endtask

    task automatic t_config_lock();
        int n;
        do_reset();
        do_write(16'hA005);
        check("R2 readback", rd_data, rd_exp(16'hA005, 12'd5));
        wait_fire(100, n);
        check("R5 expiry cycle", n, 10);
        check("R8 irq set", {31'b0, irq}, 32'h1);
        repeat (20) @(negedge clk);
        check("R8 irq held", {31'b0, irq}, 32'h1);
        check("R10 count at zero", {20'b0, rd_data[28:17]}, 32'h0);
        do_write(16'h1FFF);
        check("R3 cfg unchanged", rd_data, rd_exp(16'hA005, 12'd5));
        check("R10 irq cleared", {31'b0, irq}, 32'h0);
        wait_fire(100, n);
        check("R10 restart expiry", n, 10);
    endtask

    task automatic t_retrigger();
        int n;
        do_reset();
        do_write(16'hA008);
        repeat (6) @(negedge clk);
        check("R5 mid count", {20'b0, rd_data[28:17]}, 32'd5);
        do_write(16'h0000);
        check("R11 reloaded", {20'b0, rd_data[28:17]}, 32'd8);
        wait_fire(100, n);
        check("R11 full period", n, 16);
    endtask

    task automatic t_disabled();
        do_reset();
        do_write(16'h8007);
        repeat (50) @(negedge clk);
        check("R4 count holds", rd_data, rd_exp(16'h8007, 12'd7));
        check("R4 no irq", {31'b0, irq}, 32'h0);
        do_write(16'hA003);
        repeat (50) @(negedge clk);
        check("R4 still idle", rd_data, rd_exp(16'h8007, 12'd7));
    endtask

    task automatic t_reload_zero();
        int n;
        do_reset();
        do_write(16'hA000);
        wait_fire(100, n);
        check("R7 zero reload", n, 2);
    endtask

    task automatic t_actions();
        int n;
        do_reset();
        do_write(16'h6003);
        wait_fire(100, n);
        check("R9 act1 cycle", n, 6);
        check("R9 act1 pulse", {30'b0, irq, rst_req}, 32'h1);
        @(negedge clk);
        check("R9 act1 pulse ends", {30'b0, irq, rst_req}, 32'h0);
        do_reset();
        do_write(16'hE002);
        wait_fire(100, n);
        check("R9 act3 cycle", n, 4);
        check("R9 act3 pulse", {30'b0, irq, rst_req}, 32'h1);
        do_reset();
        do_write(16'h2002);
        wait_fire(40, n);
        check("R9 act0 silent", n, 40);
        check("R10 act0 count zero", {20'b0, rd_data[28:17]}, 32'h0);
    endtask

    task automatic t_prescale();
        int n;
        do_reset();
        do_write(16'hB001);
        wait_fire(32767, n);
        check("R6 not yet", {30'b0, irq, rst_req}, 32'h0);
        check("R6 count held", {20'b0, rd_data[28:17]}, 32'd1);
        @(negedge clk);
        check("R6 fires", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog timeout actual=%0d expected<200000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_config_lock();
        t_retrigger();
        t_disabled();
        t_reload_zero();
        t_actions();
        t_prescale();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule